// File: doc/BRIEF.md
# Tag-Matching Reservation Station

A shelving buffer that sits in front of a single execution unit. Instructions arrive from the issue stage with their operands fetched at issue time. Each arriving instruction carries an opcode and a renamed destination identifier. It also carries two source fields, and each source field is either a ready value or the tag of the rename buffer that will produce it. The station holds these instructions until every source is present. It then hands them, one per cycle, to the execution unit.

A result broadcast bus delivers each finished result together with its tag. Every slot compares that tag against its waiting sources at the same time. On a match the slot keeps the broadcast value in place of the tag and marks that source ready. A scan then picks the oldest slot whose sources are all ready, and only when the execution unit says it can accept an instruction. A flush input empties the station.

Top module: `rs_station`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `dsp_valid` and `full` are low.
- R2: An issued instruction whose sources are both marked ready (`iss_a_rdy`/`iss_b_rdy` = 1) is later dispatched with its own `iss_op`, `iss_dst` and the two given values on `dsp_op`, `dsp_dst`, `dsp_a`, `dsp_b`.
- R3: A waiting source (ready flag 0, tag in the low `TAG_W` bits) takes `bc_val` when `bc_valid` is high and `bc_tag` equals its tag. A broadcast with any other tag leaves that source waiting and leaves its value untouched.
- R4: The earliest dispatch follows the scan of the cycle after an entry is written. An instruction issued at clock edge E appears on `dsp_valid` after edge E+1 at the earliest. A source captured at edge C makes its instruction dispatchable after edge C+1 at the earliest.
- R5: An instruction issued with a waiting tag in the same cycle as a broadcast of that tag captures the broadcast value at issue.
- R6: When several entries are ready, the one issued earliest is dispatched first, whatever slot it occupies. An older entry that is still waiting does not block younger ready ones.
- R7: At most one instruction leaves per cycle. `dsp_valid` is a one-cycle pulse per dispatched instruction, and it is high after an edge only if `eu_ready` was high in the cycle before that edge.
- R8: `full` is high when all `DEPTH` slots hold an instruction. An issue presented while `full` is high is dropped and never dispatched.
- R9: A slot is freed at the same edge that its instruction is dispatched. `full` is therefore low whenever `dsp_valid` is high.
- R10: `flush` empties every slot and clears `dsp_valid` at the next edge. Nothing issued before the flush is dispatched afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Discard all held instructions |
| iss_valid | input | 1 | Issue request |
| iss_op | input | OP_W | Opcode of the issued instruction |
| iss_dst | input | TAG_W | Renamed destination identifier |
| iss_a_rdy | input | 1 | Source A carries a value (1) or a tag (0) |
| iss_a_tag | input | TAG_W | Producer tag of source A |
| iss_a_val | input | DATA_W | Value of source A |
| iss_b_rdy | input | 1 | Source B carries a value (1) or a tag (0) |
| iss_b_tag | input | TAG_W | Producer tag of source B |
| iss_b_val | input | DATA_W | Value of source B |
| full | output | 1 | No free slot; issue is refused |
| bc_valid | input | 1 | Result broadcast valid |
| bc_tag | input | TAG_W | Tag of the broadcast result |
| bc_val | input | DATA_W | Broadcast result value |
| eu_ready | input | 1 | Execution unit accepts an instruction this cycle |
| dsp_valid | output | 1 | Registered dispatch pulse |
| dsp_op | output | OP_W | Dispatched opcode |
| dsp_dst | output | TAG_W | Dispatched destination identifier |
| dsp_a | output | DATA_W | Dispatched source A value |
| dsp_b | output | DATA_W | Dispatched source B value |

## Verification
Several faults inside the station show up on the dispatch port:
- A wrong ready bit or a missed tag comparison shows up within two cycles of the broadcast. The instruction either leaves too early or carries a stale tag as its operand value, or it never leaves at all.
- A corrupt age relation shows up as dispatch order. The bench stalls the unit, frees one slot, reuses it for a younger instruction and then drains, so a faulty relation puts the destination identifiers out of order.
- A leaked or stuck slot shows up either as an instruction that was refused or flushed appearing later, or as `full` staying high after a dispatch.

// File: rtl/rs_pkg.sv
package rs_pkg;
  localparam int unsigned DEF_DEPTH  = 4;
  localparam int unsigned DEF_OP_W   = 4;
  localparam int unsigned DEF_TAG_W  = 4;
  localparam int unsigned DEF_DATA_W = 16;
  localparam int unsigned NUM_SRC    = 2;
endpackage

// File: rtl/rs_src_field.sv
// One source operand: a shared field that holds a tag while waiting
// and the operand value once ready.
module rs_src_field #(
  parameter int unsigned TAG_W  = rs_pkg::DEF_TAG_W,
  parameter int unsigned DATA_W = rs_pkg::DEF_DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              in_rdy,
  input  logic [DATA_W-1:0] in_field,
  input  logic              bc_valid,
  input  logic [TAG_W-1:0]  bc_tag,
  input  logic [DATA_W-1:0] bc_val,
  output logic              rdy,
  output logic [DATA_W-1:0] field
);
  logic hit_in, hit_held;

  assign hit_in   = bc_valid && !in_rdy && (bc_tag == in_field[TAG_W-1:0]);
  assign hit_held = bc_valid && !rdy && (bc_tag == field[TAG_W-1:0]);

  always_ff @(posedge clk) begin
    if (rst) begin
      rdy   <= 1'b0;
      field <= '0;
    end else if (load) begin
      rdy   <= in_rdy | hit_in;
      field <= hit_in ? bc_val : in_field;
    end else if (hit_held) begin
      rdy   <= 1'b1;
      field <= bc_val;
    end
  end
endmodule

// File: rtl/rs_slot.sv
module rs_slot #(
  parameter int unsigned OP_W   = rs_pkg::DEF_OP_W,
  parameter int unsigned TAG_W  = rs_pkg::DEF_TAG_W,
  parameter int unsigned DATA_W = rs_pkg::DEF_DATA_W,
  localparam int unsigned NS    = rs_pkg::NUM_SRC
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      clear,
  input  logic                      load,
  input  logic                      take,
  input  logic [OP_W-1:0]           in_op,
  input  logic [TAG_W-1:0]          in_dst,
  input  logic [NS-1:0]             in_rdy,
  input  logic [NS-1:0][DATA_W-1:0] in_field,
  input  logic                      bc_valid,
  input  logic [TAG_W-1:0]          bc_tag,
  input  logic [DATA_W-1:0]         bc_val,
  output logic                      valid,
  output logic                      ready,
  output logic [OP_W-1:0]           op,
  output logic [TAG_W-1:0]          dst,
  output logic [NS-1:0][DATA_W-1:0] src
);
  logic [NS-1:0] src_rdy;

  for (genvar s = 0; s < NS; s++) begin : g_src
    rs_src_field #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_src (
      .clk(clk), .rst(rst), .load(load),
      .in_rdy(in_rdy[s]), .in_field(in_field[s]),
      .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_val(bc_val),
      .rdy(src_rdy[s]), .field(src[s])
    );
  end

  always_ff @(posedge clk) begin
    if (rst || clear) valid <= 1'b0;
    else if (load)    valid <= 1'b1;
    else if (take)    valid <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (load) begin
      op  <= in_op;
      dst <= in_dst;
    end
  end

  assign ready = valid && (&src_rdy);
endmodule

// File: rtl/rs_alloc.sv
// Lowest-index free slot finder and full flag.
module rs_alloc #(
  parameter int unsigned DEPTH = rs_pkg::DEF_DEPTH
) (
  input  logic             iss_valid,
  input  logic             flush,
  input  logic [DEPTH-1:0] slot_valid,
  output logic [DEPTH-1:0] alloc_vec,
  output logic             full
);
  logic [DEPTH-1:0] pick;
  logic             found;

  always_comb begin
    pick  = '0;
    found = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      if (!slot_valid[i] && !found) begin
        pick[i] = 1'b1;
        found   = 1'b1;
      end
    end
  end

  assign full      = &slot_valid;
  assign alloc_vec = (iss_valid && !full && !flush) ? pick : '0;
endmodule

// File: rtl/rs_age_pick.sv
// Age matrix: older[i][j] set means slot i was written before slot j.
module rs_age_pick #(
  parameter int unsigned DEPTH = rs_pkg::DEF_DEPTH
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DEPTH-1:0] alloc_vec,
  input  logic [DEPTH-1:0] slot_valid,
  input  logic [DEPTH-1:0] slot_ready,
  output logic [DEPTH-1:0] grant
);
  logic [DEPTH-1:0][DEPTH-1:0] older;

  always_ff @(posedge clk) begin
    if (rst) begin
      older <= '0;
    end else begin
      for (int k = 0; k < DEPTH; k++) begin
        if (alloc_vec[k]) begin
          for (int j = 0; j < DEPTH; j++) begin
            older[k][j] <= 1'b0;
            if (j != k) older[j][k] <= slot_valid[j];
          end
        end
      end
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_pick
    logic [DEPTH-1:0] col;
    for (genvar j = 0; j < DEPTH; j++) begin : g_col
      assign col[j] = older[j][i];
    end
    assign grant[i] = slot_ready[i] && !(|(slot_ready & col));
  end
endmodule

// File: rtl/rs_station.sv
module rs_station #(
  parameter int unsigned DEPTH  = rs_pkg::DEF_DEPTH,
  parameter int unsigned OP_W   = rs_pkg::DEF_OP_W,
  parameter int unsigned TAG_W  = rs_pkg::DEF_TAG_W,
  parameter int unsigned DATA_W = rs_pkg::DEF_DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              iss_valid,
  input  logic [OP_W-1:0]   iss_op,
  input  logic [TAG_W-1:0]  iss_dst,
  input  logic              iss_a_rdy,
  input  logic [TAG_W-1:0]  iss_a_tag,
  input  logic [DATA_W-1:0] iss_a_val,
  input  logic              iss_b_rdy,
  input  logic [TAG_W-1:0]  iss_b_tag,
  input  logic [DATA_W-1:0] iss_b_val,
  output logic              full,
  input  logic              bc_valid,
  input  logic [TAG_W-1:0]  bc_tag,
  input  logic [DATA_W-1:0] bc_val,
  input  logic              eu_ready,
  output logic              dsp_valid,
  output logic [OP_W-1:0]   dsp_op,
  output logic [TAG_W-1:0]  dsp_dst,
  output logic [DATA_W-1:0] dsp_a,
  output logic [DATA_W-1:0] dsp_b
);
  localparam int unsigned NS = rs_pkg::NUM_SRC;

  logic [DEPTH-1:0]                      slot_valid, slot_ready, alloc_vec, grant, take_vec;
  logic [DEPTH-1:0][OP_W-1:0]            slot_op;
  logic [DEPTH-1:0][TAG_W-1:0]           slot_dst;
  logic [DEPTH-1:0][NS-1:0][DATA_W-1:0]  slot_src;
  logic [NS-1:0][DATA_W-1:0]             in_field;
  logic [NS-1:0]                         in_rdy;
  logic                                  fire;
  logic [OP_W-1:0]                       sel_op;
  logic [TAG_W-1:0]                      sel_dst;
  logic [NS-1:0][DATA_W-1:0]             sel_src;

  assign in_rdy      = {iss_b_rdy, iss_a_rdy};
  assign in_field[0] = iss_a_rdy ? iss_a_val : DATA_W'(iss_a_tag);
  assign in_field[1] = iss_b_rdy ? iss_b_val : DATA_W'(iss_b_tag);

  rs_alloc #(.DEPTH(DEPTH)) u_alloc (
    .iss_valid(iss_valid), .flush(flush), .slot_valid(slot_valid),
    .alloc_vec(alloc_vec), .full(full)
  );

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    rs_slot #(.OP_W(OP_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_slot (
      .clk(clk), .rst(rst), .clear(flush),
      .load(alloc_vec[i]), .take(take_vec[i]),
      .in_op(iss_op), .in_dst(iss_dst), .in_rdy(in_rdy), .in_field(in_field),
      .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_val(bc_val),
      .valid(slot_valid[i]), .ready(slot_ready[i]),
      .op(slot_op[i]), .dst(slot_dst[i]), .src(slot_src[i])
    );
  end

  rs_age_pick #(.DEPTH(DEPTH)) u_age (
    .clk(clk), .rst(rst), .alloc_vec(alloc_vec),
    .slot_valid(slot_valid), .slot_ready(slot_ready), .grant(grant)
  );

  assign fire     = eu_ready && (|grant) && !flush;
  assign take_vec = fire ? grant : '0;

  always_comb begin
    sel_op  = '0;
    sel_dst = '0;
    sel_src = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (grant[i]) begin
        sel_op  = sel_op  | slot_op[i];
        sel_dst = sel_dst | slot_dst[i];
        sel_src = sel_src | slot_src[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || flush) dsp_valid <= 1'b0;
    else              dsp_valid <= fire;
  end

  always_ff @(posedge clk) begin
    if (fire) begin
      dsp_op  <= sel_op;
      dsp_dst <= sel_dst;
      dsp_a   <= sel_src[0];
      dsp_b   <= sel_src[1];
    end
  end
endmodule

// File: rtl/rs_station_chk.sv
module rs_station_chk #(
  parameter int unsigned DEPTH = rs_pkg::DEF_DEPTH
) (
  input logic             clk,
  input logic             rst,
  input logic             flush,
  input logic             eu_ready,
  input logic             dsp_valid,
  input logic             full,
  input logic [DEPTH-1:0] slot_valid,
  input logic [DEPTH-1:0] grant
);
  // R7: nothing leaves unless the unit was ready in the cycle before
  a_r7_ready_gate: assert property (@(posedge clk) disable iff (rst)
    !eu_ready |=> !dsp_valid);

  // R7: the scan selects at most one slot
  a_r7_single_pick: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant));

  // R9: a dispatching edge always leaves a free slot
  a_r9_dispatch_frees: assert property (@(posedge clk) disable iff (rst)
    dsp_valid |-> !full);

  // R8: occupancy grows by at most one per cycle
  a_r8_one_alloc: assert property (@(posedge clk) disable iff (rst)
    !flush |=> $countones(slot_valid) <= $past($countones(slot_valid)) + 1);

  // R10: flush empties everything at the next edge
  a_r10_flush_clears: assert property (@(posedge clk) disable iff (rst)
    flush |=> (!dsp_valid && slot_valid == '0));
endmodule

bind rs_station rs_station_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .flush(flush), .eu_ready(eu_ready),
  .dsp_valid(dsp_valid), .full(full), .slot_valid(slot_valid), .grant(grant)
);

// File: tb/tb_rs_station.sv
`timescale 1ns/1ps
module tb_rs_station;
  localparam int OP_W = 4, TAG_W = 4, DATA_W = 16, DEPTH = 4;

  logic clk = 1'b0;
  logic rst = 1'b1, flush = 1'b0;
  logic iss_valid = 1'b0;
  logic [OP_W-1:0] iss_op = '0;
  logic [TAG_W-1:0] iss_dst = '0, iss_a_tag = '0, iss_b_tag = '0, bc_tag = '0;
  logic iss_a_rdy = 1'b0, iss_b_rdy = 1'b0, bc_valid = 1'b0, eu_ready = 1'b0;
  logic [DATA_W-1:0] iss_a_val = '0, iss_b_val = '0, bc_val = '0;
  logic full, dsp_valid;
  logic [OP_W-1:0] dsp_op;
  logic [TAG_W-1:0] dsp_dst;
  logic [DATA_W-1:0] dsp_a, dsp_b;

  always #10 clk = ~clk;

  rs_station #(.DEPTH(DEPTH), .OP_W(OP_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) dut (.*);

  int checks = 0, errors = 0;
  bit done = 1'b0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  // Drives one cycle of issue and/or broadcast, returns at the next negedge.
  task automatic drive(input bit iv, input logic [3:0] op, input logic [3:0] dst,
                       input bit ar, input logic [3:0] at, input logic [15:0] av,
                       input bit br, input logic [3:0] bt, input logic [15:0] bv,
                       input bit bcv, input logic [3:0] bct, input logic [15:0] bcd);
    iss_valid = iv; iss_op = op; iss_dst = dst;
    iss_a_rdy = ar; iss_a_tag = at; iss_a_val = av;
    iss_b_rdy = br; iss_b_tag = bt; iss_b_val = bv;
    bc_valid = bcv; bc_tag = bct; bc_val = bcd;
    tick();
    iss_valid = 1'b0; bc_valid = 1'b0;
  endtask

  task automatic issue_rdy(input logic [3:0] dst);
    drive(1, 4'h1, dst, 1, 0, 16'(dst), 1, 0, 16'h0, 0, 0, 0);
  endtask

  typedef struct packed {
    logic [3:0]  op;  logic [3:0] dst;
    logic        ar;  logic [3:0] at; logic [15:0] av;
    logic        br;  logic [3:0] bt; logic [15:0] bv;
    logic [1:0]  nbc;
    logic [3:0]  t0;  logic [15:0] v0;
    logic [3:0]  t1;  logic [15:0] v1;
    logic [15:0] ea;  logic [15:0] eb;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{4'h1, 4'h1, 1'b1, 4'h0, 16'h1111, 1'b1, 4'h0, 16'h2222, 2'd0, 4'h0, 16'h0,    4'h0, 16'h0,    16'h1111, 16'h2222},
    '{4'h2, 4'h2, 1'b0, 4'h3, 16'h0,    1'b1, 4'h0, 16'h0B0B, 2'd1, 4'h3, 16'h3333, 4'h0, 16'h0,    16'h3333, 16'h0B0B},
    '{4'h3, 4'h3, 1'b1, 4'h0, 16'h0A0A, 1'b0, 4'h7, 16'h0,    2'd2, 4'h9, 16'hDEAD, 4'h7, 16'h7777, 16'h0A0A, 16'h7777},
    '{4'h4, 4'h4, 1'b0, 4'h5, 16'h0,    1'b0, 4'h6, 16'h0,    2'd2, 4'h6, 16'h6666, 4'h5, 16'h5555, 16'h5555, 16'h6666},
    '{4'h5, 4'h5, 1'b0, 4'h2, 16'h0,    1'b0, 4'h2, 16'h0,    2'd1, 4'h2, 16'h2020, 4'h0, 16'h0,    16'h2020, 16'h2020},
    '{4'hF, 4'hF, 1'b1, 4'h0, 16'hFFFF, 1'b1, 4'h0, 16'h0000, 2'd0, 4'h0, 16'h0,    4'h0, 16'h0,    16'hFFFF, 16'h0000}
  };

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    bit seen;
    // R1 reset
    tick(); tick();
    check(!dsp_valid && !full, "R1 reset outputs", {dsp_valid, full}, 0);
    rst = 1'b0;
    tick();
    check(!dsp_valid && !full, "R1 after reset", {dsp_valid, full}, 0);

    // R2/R3 vector table
    eu_ready = 1'b1;
    for (int v = 0; v < 6; v++) begin
      vec_t t = VECS[v];
      drive(1, t.op, t.dst, t.ar, t.at, t.av, t.br, t.bt, t.bv, 0, 0, 0);
      for (int b = 0; b < int'(t.nbc); b++) begin
        check(!dsp_valid, "R3 waiting source held back", dsp_valid, 0);
        if (b == 0) drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, t.t0, t.v0);
        else        drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, t.t1, t.v1);
      end
      seen = 1'b0;
      for (int w = 0; w < 8 && !seen; w++) begin
        if (dsp_valid) seen = 1'b1; else tick();
      end
      check(seen, "R2 vector dispatched", seen, 1);
      check(dsp_op == t.op && dsp_dst == t.dst, "R2 op/dst", {dsp_op, dsp_dst}, {t.op, t.dst});
      check(dsp_a == t.ea, "R3 source A value", dsp_a, t.ea);
      check(dsp_b == t.eb, "R3 source B value", dsp_b, t.eb);
      tick();
    end

    // R4 timing from issue and from capture
    issue_rdy(4'h6);
    check(!dsp_valid, "R4 not same-edge after issue", dsp_valid, 0);
    tick();
    check(dsp_valid && dsp_dst == 4'h6, "R4 dispatch one edge later", {dsp_valid, dsp_dst}, {1'b1, 4'h6});
    drive(1, 4'h2, 4'h7, 0, 4'h8, 0, 1, 0, 16'h0001, 0, 0, 0);
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 4'h8, 16'h8888);
    check(!dsp_valid, "R4 captured source not ready same cycle", dsp_valid, 0);
    tick();
    check(dsp_valid && dsp_a == 16'h8888, "R4 dispatch after capture", dsp_a, 16'h8888);

    // R5 issue and broadcast in the same cycle
    tick();
    drive(1, 4'h3, 4'h9, 0, 4'hA, 0, 1, 0, 16'h0002, 1, 4'hA, 16'hAAAA);
    tick();
    check(dsp_valid && dsp_a == 16'hAAAA, "R5 same-cycle capture", dsp_a, 16'hAAAA);
    tick();

    // R6 older waiting entry does not block, then leaves before younger
    eu_ready = 1'b0;
    drive(1, 4'h1, 4'h1, 0, 4'h4, 0, 1, 0, 0, 0, 0, 0);
    issue_rdy(4'h2);
    issue_rdy(4'h3);
    eu_ready = 1'b1;
    tick();
    check(dsp_valid && dsp_dst == 4'h2, "R6 ready younger first", dsp_dst, 4'h2);
    tick();
    check(dsp_valid && dsp_dst == 4'h3, "R6 next ready", dsp_dst, 4'h3);
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 4'h4, 16'h4444);
    tick();
    check(dsp_valid && dsp_dst == 4'h1, "R6 released waiting entry", dsp_dst, 4'h1);
    tick();

    // R7/R8/R9 fill, stall, refuse, free one, reuse slot, drain in age order
    eu_ready = 1'b0;
    for (int k = 8; k < 12; k++) begin
      issue_rdy(4'(k));
      check(!dsp_valid, "R7 stalled unit gets nothing", dsp_valid, 0);
    end
    check(full, "R8 full after DEPTH issues", full, 1);
    issue_rdy(4'hD);
    tick();
    check(!dsp_valid, "R7 still stalled", dsp_valid, 0);
    eu_ready = 1'b1;
    tick();
    eu_ready = 1'b0;
    check(dsp_valid && dsp_dst == 4'h8, "R6 oldest of full set", dsp_dst, 4'h8);
    check(!full, "R9 slot freed at dispatch", full, 0);
    tick();
    check(!dsp_valid, "R7 single pulse", dsp_valid, 0);
    issue_rdy(4'hC);
    eu_ready = 1'b1;
    for (int k = 9; k < 13; k++) begin
      tick();
      check(dsp_valid && dsp_dst == 4'(k), "R6 age order across slot reuse", dsp_dst, k);
    end
    seen = 1'b0;
    for (int w = 0; w < 4; w++) begin
      tick();
      if (dsp_valid) seen = 1'b1;
    end
    check(!seen, "R8 refused issue never dispatched", seen, 0);

    // R10 flush
    eu_ready = 1'b0;
    issue_rdy(4'h3);
    issue_rdy(4'h4);
    flush = 1'b1;
    tick();
    flush = 1'b0;
    eu_ready = 1'b1;
    seen = 1'b0;
    for (int w = 0; w < 5; w++) begin
      if (dsp_valid) seen = 1'b1;
      tick();
    end
    check(!seen && !full, "R10 flush discards entries", {seen, full}, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule